// File: doc/BRIEF.md
# Control Transfer Resolution Unit

This block decides where a 32-bit integer core fetches next after a conditional branch or an unconditional jump. Each valid cycle it takes the operation kind, the two source operands, the current program counter and an offset that the decoder has already sign-extended to full width. It evaluates the branch condition and forms the target address. It reports the next fetch address, a redirect flag, the return address to be written to the destination register, and an exception flag for a target that is not aligned.

The core is assumed to run 16-bit compressed instructions, so the default alignment rule is 2 bytes. A parameter selects 4-byte alignment for cores without compressed support. A faulting transfer never redirects, and a branch that is not taken never faults. All results are registered and qualified by a valid strobe one cycle after the request. Fetch, pipeline flush and trap entry are left to the surrounding core.

Top module: `xfer_resolve_unit`

## Requirements
- R1: While `rstN` is low and on the first cycle after it rises, `outValid`, `taken` and `fault` are 0, and `nextPc` and `linkVal` are zero.
- R2: A request with `inValid` high at a rising edge shows its results on the outputs after that edge, with `outValid` high. After an edge where `inValid` is low, `outValid`, `taken` and `fault` are 0 and `nextPc` and `linkVal` are zero.
- R3: `opKind` encodes 0 = equal, 1 = not equal, 2 = signed less-than, 3 = signed greater-or-equal, 4 = unsigned less-than, 5 = unsigned greater-or-equal, 6 = PC-relative jump, 7 = register-indirect jump. Each condition compares `srcA` against `srcB`.
- R4: When a branch condition holds, `nextPc` = `pcIn` + `offset` with bit 0 of `offset` taken as zero, and `taken` = 1. When the condition fails, `nextPc` = `pcIn` + 4 and `taken` = 0.
- R5: Code 6 always redirects to `pcIn` + `offset`, with bit 0 of `offset` taken as zero.
- R6: Code 7 redirects to (`srcA` + `offset`) with bit 0 of the sum forced to zero. Bit 0 of `offset` takes part in the addition.
- R7: For codes 6 and 7 without a fault, `linkVal` = `pcIn` + 4, where `pcIn` is the original PC. For branches `linkVal` is zero.
- R8: A branch whose condition fails never sets `fault`, even when `pcIn` is odd.
- R9: A redirect whose target has a bit set below the alignment granule (bit 0 by default) sets `fault` = 1, `taken` = 0, `linkVal` = 0 and `nextPc` = `pcIn`.
- R10: All address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Request present this cycle |
| opKind | input | 3 | Operation code (see R3) |
| srcA | input | 32 | First source operand, also the base for code 7 |
| srcB | input | 32 | Second source operand |
| pcIn | input | 32 | Address of the transfer instruction |
| offset | input | 32 | Sign-extended immediate offset |
| outValid | output | 1 | Registered results are valid |
| nextPc | output | 32 | Next fetch address, or the faulting PC |
| taken | output | 1 | Fetch must redirect to `nextPc` |
| fault | output | 1 | Misaligned target exception |
| linkVal | output | 32 | Return address for the destination register |

## Verification
The assertions check on every cycle that the valid strobe follows the request one cycle later and that idle cycles leave the outputs at zero. They also check that a fault never appears together with a redirect or a link value, that every redirect address is aligned, that a failing equality branch steps by four without faulting, and that a register-indirect jump links to PC plus four. Only the bench's scenarios show the correct target for each condition under signed versus unsigned operands, the handling of the low offset bit for each kind, wrap-around at the top of the address space, and faults raised from an odd PC.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [2:0] {
    OP_BEQ  = 3'd0,
    OP_BNE  = 3'd1,
    OP_BLT  = 3'd2,
    OP_BGE  = 3'd3,
    OP_BLTU = 3'd4,
    OP_BGEU = 3'd5,
    OP_JAL  = 3'd6,
    OP_JALR = 3'd7
  } xferOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic isJump;      // unconditional transfer
    logic useRegBase;  // base is srcA, full offset, clear sum bit 0
    logic condMet;     // branch condition evaluated true
  } xferStrobe_t;

endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]      opKind,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  output xferStrobe_t     strobe
);

  xferOp_e opCode;
  logic    eqFlag;
  logic    ltSigned;
  logic    ltUnsigned;

  assign opCode     = xferOp_e'(opKind);
  assign eqFlag     = (srcA == srcB);
  assign ltSigned   = ($signed(srcA) < $signed(srcB));
  assign ltUnsigned = (srcA < srcB);

  always_comb begin
    strobe = '0;
    unique case (opCode)
      OP_BEQ:  strobe.condMet = eqFlag;
      OP_BNE:  strobe.condMet = !eqFlag;
      OP_BLT:  strobe.condMet = ltSigned;
      OP_BGE:  strobe.condMet = !ltSigned;
      OP_BLTU: strobe.condMet = ltUnsigned;
      OP_BGEU: strobe.condMet = !ltUnsigned;
      OP_JAL:  strobe.isJump  = 1'b1;
      OP_JALR: begin
        strobe.isJump     = 1'b1;
        strobe.useRegBase = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
#(
  parameter int XLEN           = 32,
  parameter bit HAS_COMPRESSED = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  xferStrobe_t     strobe,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] pcIn,
  input  logic [XLEN-1:0] offset,
  output logic            outValid,
  output logic [XLEN-1:0] nextPc,
  output logic            taken,
  output logic            fault,
  output logic [XLEN-1:0] linkVal
);

  localparam int ALIGN_LSBS = HAS_COMPRESSED ? 1 : 2;
  localparam logic [XLEN-1:0] INSN_STEP = XLEN'(4);

  logic [XLEN-1:0] baseAddr;
  logic [XLEN-1:0] addOffset;
  logic [XLEN-1:0] rawSum;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] seqPc;
  logic            redirect;
  logic            misalign;
  logic            faultD;
  logic            takenD;
  logic [XLEN-1:0] nextD;
  logic [XLEN-1:0] linkD;

  assign baseAddr  = strobe.useRegBase ? srcA : pcIn;
  assign addOffset = strobe.useRegBase ? offset : {offset[XLEN-1:1], 1'b0};
  assign rawSum    = baseAddr + addOffset;
  assign target    = strobe.useRegBase ? {rawSum[XLEN-1:1], 1'b0} : rawSum;
  assign seqPc     = pcIn + INSN_STEP;
  assign redirect  = strobe.isJump | strobe.condMet;

  generate
    if (HAS_COMPRESSED) begin : g_half_align
      assign misalign = target[0];
    end else begin : g_word_align
      assign misalign = |target[ALIGN_LSBS-1:0];
    end
  endgenerate

  assign faultD = redirect & misalign;
  assign takenD = redirect & !misalign;

  always_comb begin
    if (faultD)      nextD = pcIn;
    else if (takenD) nextD = target;
    else             nextD = seqPc;
    linkD = (strobe.isJump && !faultD) ? seqPc : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !inValid) begin
      outValid <= 1'b0;
      nextPc   <= '0;
      taken    <= 1'b0;
      fault    <= 1'b0;
      linkVal  <= '0;
    end else begin
      outValid <= 1'b1;
      nextPc   <= nextD;
      taken    <= takenD;
      fault    <= faultD;
      linkVal  <= linkD;
    end
  end

endmodule

// File: rtl/xfer_resolve_unit.sv
module xfer_resolve_unit
  import xfer_pkg::*;
#(
  parameter int XLEN           = 32,
  parameter bit HAS_COMPRESSED = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [2:0]      opKind,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  input  logic [XLEN-1:0] pcIn,
  input  logic [XLEN-1:0] offset,
  output logic            outValid,
  output logic [XLEN-1:0] nextPc,
  output logic            taken,
  output logic            fault,
  output logic [XLEN-1:0] linkVal
);

  xferStrobe_t strobe;

  xfer_ctrl #(.XLEN(XLEN)) u_ctrl (
    .opKind (opKind),
    .srcA   (srcA),
    .srcB   (srcB),
    .strobe (strobe)
  );

  xfer_datapath #(.XLEN(XLEN), .HAS_COMPRESSED(HAS_COMPRESSED)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .srcA     (srcA),
    .pcIn     (pcIn),
    .offset   (offset),
    .outValid (outValid),
    .nextPc   (nextPc),
    .taken    (taken),
    .fault    (fault),
    .linkVal  (linkVal)
  );

endmodule

// File: rtl/xfer_resolve_chk.sv
module xfer_resolve_chk #(
  parameter int XLEN           = 32,
  parameter bit HAS_COMPRESSED = 1'b1
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic [2:0]      opKind,
  input logic [XLEN-1:0] srcA,
  input logic [XLEN-1:0] srcB,
  input logic [XLEN-1:0] pcIn,
  input logic [XLEN-1:0] offset,
  input logic            outValid,
  input logic [XLEN-1:0] nextPc,
  input logic            taken,
  input logic            fault,
  input logic [XLEN-1:0] linkVal
);

  localparam logic [XLEN-1:0] GRAIN_MASK = HAS_COMPRESSED ? XLEN'(1) : XLEN'(3);
  localparam logic [XLEN-1:0] STEP4 = XLEN'(4);

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !taken && !fault && nextPc == '0 && linkVal == '0));

  assert_fault_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (!taken && linkVal == '0));

  assert_redirect_aligned_R9: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> ((nextPc & GRAIN_MASK) == '0));

  assert_ne_no_fault_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opKind == 3'd0 && srcA != srcB) |=>
      (!fault && !taken && nextPc == $past(pcIn) + STEP4));

  assert_indirect_link_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opKind == 3'd7 && HAS_COMPRESSED) |=>
      (!fault && taken && linkVal == $past(pcIn) + STEP4 && !nextPc[0]));

endmodule

bind xfer_resolve_unit xfer_resolve_chk #(
  .XLEN(XLEN), .HAS_COMPRESSED(HAS_COMPRESSED)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opKind(opKind),
  .srcA(srcA), .srcB(srcB), .pcIn(pcIn), .offset(offset),
  .outValid(outValid), .nextPc(nextPc), .taken(taken),
  .fault(fault), .linkVal(linkVal)
);

// File: tb/xfer_resolve_unit_bench.sv
`timescale 1ns/1ps
module xfer_resolve_unit_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [2:0]  opKind;
  logic [31:0] srcA, srcB, pcIn, offset;
  logic        outValid, taken, fault;
  logic [31:0] nextPc, linkVal;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // expectation for the outputs after the next edge
  logic        expValid, expTaken, expFault;
  logic [31:0] expNext, expLink;
  string       expReq;

  always #4 clk = ~clk;

  xfer_resolve_unit u_xfer_resolve_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opKind(opKind),
    .srcA(srcA), .srcB(srcB), .pcIn(pcIn), .offset(offset),
    .outValid(outValid), .nextPc(nextPc), .taken(taken),
    .fault(fault), .linkVal(linkVal)
  );

  // behavioural reference from the requirements
  task automatic model(input int op, input logic [31:0] a, b, pc, off);
    bit go;
    logic [31:0] tgt;
    case (op)
      0: go = (a == b);
      1: go = (a != b);
      2: go = ($signed(a) < $signed(b));
      3: go = !($signed(a) < $signed(b));
      4: go = (a < b);
      5: go = !(a < b);
      default: go = 1'b1;
    endcase
    if (op == 7) tgt = (a + off) & 32'hFFFF_FFFE;
    else         tgt = pc + (off & 32'hFFFF_FFFE);
    expValid = 1'b1;
    if (go && tgt[0]) begin
      expFault = 1'b1; expTaken = 1'b0; expNext = pc; expLink = 32'd0;
    end else begin
      expFault = 1'b0; expTaken = go;
      expNext = go ? tgt : pc + 32'd4;
      expLink = (op >= 6) ? pc + 32'd4 : 32'd0;
    end
  endtask

  task automatic compare();
    compared++;
    if (outValid !== expValid || taken !== expTaken || fault !== expFault ||
        nextPc !== expNext || linkVal !== expLink) begin
      mismatched++;
      $display("FAIL %s: got v=%0b t=%0b f=%0b next=%h link=%h exp v=%0b t=%0b f=%0b next=%h link=%h",
               expReq, outValid, taken, fault, nextPc, linkVal,
               expValid, expTaken, expFault, expNext, expLink);
    end
  endtask

  task automatic set_zero_exp(input string req);
    expValid = 0; expTaken = 0; expFault = 0; expNext = 0; expLink = 0; expReq = req;
  endtask

  task automatic issue(input int op, input logic [31:0] a, b, pc, off, input string req);
    @(negedge clk);
    compare();
    inValid = 1'b1; opKind = 3'(op); srcA = a; srcB = b; pcIn = pc; offset = off;
    model(op, a, b, pc, off);
    expReq = req;
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    compare();
    inValid = 1'b0; opKind = 3'd0; srcA = 32'hDEAD_BEEF; srcB = 32'h1234_5678;
    pcIn = 32'h0000_1001; offset = 32'h0000_0040;
    set_zero_exp(req);
  endtask

  initial begin
    rstN = 1'b0; inValid = 1'b1; opKind = 3'd6;
    srcA = 0; srcB = 0; pcIn = 32'h100; offset = 32'h20;
    set_zero_exp("R1");
    repeat (3) @(posedge clk);
    @(negedge clk); compare();          // R1 during reset
    rstN = 1'b1; inValid = 1'b0;
    set_zero_exp("R1");

    // R3 conditions, signed vs unsigned operands
    issue(0, 32'd5, 32'd5, 32'h1000, 32'h40, "R3");
    issue(0, 32'd5, 32'd6, 32'h1000, 32'h40, "R3");
    issue(1, 32'd5, 32'd6, 32'h1000, 32'h40, "R3");
    issue(1, 32'd7, 32'd7, 32'h1000, 32'h40, "R3");
    issue(2, 32'hFFFF_FFFF, 32'd1, 32'h2000, 32'h10, "R3");
    issue(4, 32'hFFFF_FFFF, 32'd1, 32'h2000, 32'h10, "R3");
    issue(3, 32'hFFFF_FFFF, 32'd1, 32'h2000, 32'h10, "R3");
    issue(5, 32'hFFFF_FFFF, 32'd1, 32'h2000, 32'h10, "R3");
    issue(3, 32'd9, 32'd9, 32'h2000, 32'h10, "R3");
    issue(4, 32'd9, 32'd9, 32'h2000, 32'h10, "R3");
    // R4 offset bit 0 ignored, negative offset
    issue(0, 32'd1, 32'd1, 32'h3000, 32'h0000_0021, "R4");
    issue(5, 32'd8, 32'd2, 32'h3000, 32'hFFFF_FFF0, "R4");
    // R5 / R7 pc-relative jump
    issue(6, 32'd0, 32'd0, 32'h4000, 32'h0000_0801, "R5");
    issue(6, 32'd0, 32'd0, 32'h4000, 32'hFFF0_0000, "R7");
    // R6 / R7 register jump with odd sum
    issue(7, 32'h5003, 32'd0, 32'h7000, 32'h0000_0002, "R6");
    issue(7, 32'h5000, 32'd0, 32'h7000, 32'hFFFF_FFFF, "R6");
    // R2 idle gap
    idle("R2");
    idle("R2");
    // R8 odd pc, condition fails
    issue(0, 32'd1, 32'd2, 32'h0000_0101, 32'h40, "R8");
    issue(2, 32'd5, 32'd1, 32'h0000_0103, 32'h40, "R8");
    // R9 odd pc redirect
    issue(0, 32'd3, 32'd3, 32'h0000_0101, 32'h40, "R9");
    issue(6, 32'd0, 32'd0, 32'h0000_0201, 32'h8, "R9");
    // R10 wrap-around
    issue(1, 32'd1, 32'd1, 32'hFFFF_FFFC, 32'h40, "R10");
    issue(6, 32'd0, 32'd0, 32'hFFFF_FFF0, 32'h20, "R10");
    issue(7, 32'hFFFF_FFFE, 32'd0, 32'hFFFF_FFFC, 32'h6, "R10");
    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      if (($urandom % 5) == 0) idle("R2");
      else issue(int'($urandom % 8), $urandom, ($urandom % 3 == 0) ? 32'd77 : $urandom,
                 $urandom, $urandom, "R3");
    end
    idle("R2");
    idle("R2");
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule